// File: doc/BRIEF.md
# Open-Row DRAM Read Sequencer

This block sits between a single-word read requester and one bank of DRAM whose address pins are shared between row and column. Each request carries a 24-bit location. The upper part selects a row and the lower part selects a column. The block keeps the last row it opened active. A request that lands in that row is served with a column-only strobe cycle, which is short. A request to any other row first releases the row strobe for a precharge interval and then runs a complete row-then-column access. After reset no row is open, so the first access is always a complete one.

All DRAM timing is counted in clock cycles and set by parameters. With the default 5 ns clock these are:

- complete access: 12 cycles to data, 22 cycles before the next access may start;
- page access: 5 cycles to data, 8 cycles before the next access may start;
- precharge: 4 cycles;
- row-to-column delay: 2 cycles.

The requester sees a valid/ready handshake. Read data comes back with a one-cycle valid pulse, exactly at the latency that belongs to the kind of access that was chosen.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is asserted and directly after it, req_ready is 1, dram_ras_n and dram_cas_n are 1, and rd_valid is 0. No row counts as open.
- R2: The row is req_addr[23:11] and the column is req_addr[10:0]. The row is driven on dram_addr in the cycle in which dram_ras_n falls. The column, zero-extended to 13 bits, is driven on dram_addr during every cycle in which dram_cas_n is low.
- R3: When no row is open, a request accepted at clock edge k drops dram_ras_n at edge k. It delivers data at edge k+12, and req_ready returns high after edge k+22.
- R4: When the request's row equals the open row, dram_ras_n stays low with no change and dram_cas_n falls at the accept edge k. Data is delivered at edge k+5, and req_ready returns high after edge k+8.
- R5: When a different row is open, dram_ras_n rises at the accept edge k and stays high for 4 cycles. The new row then opens at edge k+4, followed by a complete access: data at edge k+16, and req_ready high again after edge k+26.
- R6: A request is accepted only at a clock edge where req_valid and req_ready are both 1. A request presented while req_ready is 0 has no effect on the pins, the open row or the returned data.
- R7: rd_valid is high for exactly one cycle per accepted request. rd_data then holds the word that the DRAM drove on dram_dq while dram_cas_n was low. dram_cas_n rises at the same edge.
- R8: dram_cas_n is low only while dram_ras_n is low.
- R9: In a complete access, dram_cas_n falls 2 cycles after dram_ras_n falls.
- R10: dram_addr does not change while dram_cas_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 24 | Location address: row in the upper 13 bits, column in the lower 11 bits |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | 13 | Multiplexed row/column address pins |
| dram_dq | input | 32 | Read data from the DRAM |
| rd_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | 32 | Returned read word |

## Verification
The assertions check the strobe relationships on every cycle. They check that the column strobe only occurs under an active row strobe and that the address holds while the column strobe is low. They also check that the data pulse is a single cycle, lands while the block is busy and coincides with the column strobe being released, and that a row-strobe release lasts more than one cycle. The exact latency and cycle counts for each of the three access kinds can only be shown by the bench scenarios. The same holds for the choice between page hit, precharge and first access, the correct row/column split, the returned word, and the fact that requests offered during a busy interval are ignored. The bench's reference model predicts each of these per cycle from the accepted request stream.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_FULL = 2'd2,
    ST_PAGE = 2'd3
  } dps_state_e;
endpackage

// File: rtl/dps_row_tracker.sv
module dps_row_tracker #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] load_row,
  input  logic [ROW_W-1:0] cmp_row,
  output logic             row_open,
  output logic             row_hit
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (load) begin
      open_q <= 1'b1;
      row_q  <= load_row;
    end
  end

  assign row_open = open_q;
  assign row_hit  = open_q && (row_q == cmp_row);
endmodule

// File: rtl/dps_cycle_timer.sv
module dps_cycle_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int ROW_W     = 13,
  parameter int COL_W     = 11,
  parameter int DATA_W    = 32,
  parameter int FULL_LAT  = 12,
  parameter int FULL_CYC  = 22,
  parameter int PAGE_LAT  = 5,
  parameter int PAGE_CYC  = 8,
  parameter int PRE_CYC   = 4,
  parameter int RCD_CYC   = 2,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic [PIN_W-1:0]  dram_addr,
  input  logic [DATA_W-1:0] dram_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  import dps_pkg::*;

  localparam int MAX_CYC = (FULL_CYC > PRE_CYC) ? FULL_CYC : PRE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PRE_END   = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] RCD_END   = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] FLAT_END  = CNT_W'(FULL_LAT - 1);
  localparam logic [CNT_W-1:0] FCYC_END  = CNT_W'(FULL_CYC - 1);
  localparam logic [CNT_W-1:0] PLAT_END  = CNT_W'(PAGE_LAT - 1);
  localparam logic [CNT_W-1:0] PCYC_END  = CNT_W'(PAGE_CYC - 1);

  dps_state_e        state_q, state_d;
  logic              ras_n_q, ras_n_d;
  logic              cas_n_q, cas_n_d;
  logic [PIN_W-1:0]  addr_q, addr_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic              valid_q, capture;
  logic [DATA_W-1:0] data_q;

  logic              accept;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  in_col;
  logic              row_load, row_open, row_hit;
  logic [ROW_W-1:0]  load_row;
  logic              cnt_clr, cnt_en;
  logic [CNT_W-1:0]  cnt;

  assign in_row    = req_addr[ADDR_W-1:COL_W];
  assign in_col    = req_addr[COL_W-1:0];
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  dps_row_tracker #(.ROW_W(ROW_W)) i_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (row_load),
    .load_row (load_row),
    .cmp_row  (in_row),
    .row_open (row_open),
    .row_hit  (row_hit)
  );

  dps_cycle_timer #(.CNT_W(CNT_W)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .count (cnt)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ras_n_d  = ras_n_q;
    cas_n_d  = cas_n_q;
    addr_d   = addr_q;
    row_d    = row_q;
    col_d    = col_q;
    capture  = 1'b0;
    row_load = 1'b0;
    load_row = in_row;
    cnt_clr  = 1'b0;
    cnt_en   = (state_q != ST_IDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          row_d   = in_row;
          col_d   = in_col;
          cnt_clr = 1'b1;
          if (row_hit) begin
            state_d = ST_PAGE;
            cas_n_d = 1'b0;
            addr_d  = PIN_W'(in_col);
          end else if (row_open) begin
            state_d = ST_PRE;
            ras_n_d = 1'b1;
          end else begin
            state_d  = ST_FULL;
            ras_n_d  = 1'b0;
            addr_d   = PIN_W'(in_row);
            row_load = 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (cnt == PRE_END) begin
          state_d  = ST_FULL;
          ras_n_d  = 1'b0;
          addr_d   = PIN_W'(row_q);
          load_row = row_q;
          row_load = 1'b1;
          cnt_clr  = 1'b1;
        end
      end
      ST_FULL: begin
        if (cnt == RCD_END) begin
          cas_n_d = 1'b0;
          addr_d  = PIN_W'(col_q);
        end
        if (cnt == FLAT_END) begin
          capture = 1'b1;
          cas_n_d = 1'b1;
        end
        if (cnt == FCYC_END) state_d = ST_IDLE;
      end
      ST_PAGE: begin
        if (cnt == PLAT_END) begin
          capture = 1'b1;
          cas_n_d = 1'b1;
        end
        if (cnt == PCYC_END) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      addr_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ras_n_q <= ras_n_d;
      cas_n_q <= cas_n_d;
      addr_q  <= addr_d;
      row_q   <= row_d;
      col_q   <= col_d;
      valid_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= dram_dq;
  end

  assign dram_ras_n = ras_n_q;
  assign dram_cas_n = cas_n_q;
  assign dram_addr  = addr_q;
  assign rd_valid   = valid_q;
  assign rd_data    = data_q;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int PIN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             dram_ras_n,
  input logic             dram_cas_n,
  input logic [PIN_W-1:0] dram_addr,
  input logic             rd_valid
);
  a_r8_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);

  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r7_cas_released: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> dram_cas_n);

  a_r6_busy_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

  a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_addr));

  a_r5_precharge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |=> dram_ras_n);
endmodule

bind dram_page_seq dps_checker #(.PIN_W(PIN_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_addr  (dram_addr),
  .rd_valid   (rd_valid)
);

// File: tb/test_dram_page_seq.sv
module test_dram_page_seq;
  localparam int FLAT = 12, FCYC = 22, PLAT = 5, PCYC = 8, PRE = 4, RCD = 2;
  localparam longint BIG = 64'd1 << 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        dram_ras_n, dram_cas_n;
  logic [12:0] dram_addr;
  logic [31:0] dram_dq = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_page_seq i_dram_page_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_addr(dram_addr), .dram_dq(dram_dq), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [31:0] pat(input int r, input int c);
    return (32'(r) * 32'd2048 + 32'(c)) * 32'h9E3779B1 ^ 32'h5A5A0F0F;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // DRAM behaviour: latch row and column on strobe falls, drive the word while column strobe is low
  logic ras_prev = 1'b1, cas_prev = 1'b1;
  int row_l = 0, col_l = 0;
  always @(negedge clk) begin
    if (!dram_ras_n && ras_prev) row_l = int'(dram_addr);
    if (!dram_cas_n && cas_prev) col_l = int'(dram_addr);
    ras_prev = dram_ras_n;
    cas_prev = dram_cas_n;
    dram_dq <= !dram_cas_n ? pat(row_l, col_l) : 32'h0;
  end

  // reference model: event times per accepted request
  longint n = 0, t_ready = 0, ras_fall = BIG, cas_on = BIG, data_t = BIG;
  bit     open = 1'b0;
  int     open_row = 0, e_row = 0, e_col = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n = 0; t_ready = 0; ras_fall = BIG; cas_on = BIG; data_t = BIG; open = 1'b0;
    end else begin
      n++;
      if (req_valid && (n - 1) >= t_ready) begin
        longint s;
        e_row = int'(req_addr[23:11]);
        e_col = int'(req_addr[10:0]);
        if (open && e_row == open_row) begin
          cas_on = n; data_t = n + PLAT; t_ready = n + PCYC;
        end else begin
          s = open ? n + PRE : n;
          ras_fall = s; cas_on = s + RCD; data_t = s + FLAT; t_ready = s + FCYC;
        end
        open = 1'b1;
        open_row = e_row;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 R4 R5 R6 ready", req_ready, n >= t_ready);
      chk("R3 R5 ras_n", dram_ras_n, !(n >= ras_fall));
      chk("R4 R9 cas_n", dram_cas_n, !(n >= cas_on && n < data_t));
      chk("R7 rd_valid", rd_valid, n == data_t);
      if (n == data_t) chk("R7 rd_data", rd_data, pat(e_row, e_col));
      if (!dram_cas_n) begin
        chk("R2 R10 column on pins", dram_addr, e_col);
        chk("R8 cas under ras", dram_ras_n, 0);
      end
      if (n == ras_fall) chk("R2 row on pins", dram_addr, e_row);
    end
  end

  task automatic issue(input int r, input int c);
    req_valid = 1'b1;
    req_addr  = {13'(r), 11'(c)};
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    chk("R1 ras_n in reset", dram_ras_n, 1);
    chk("R1 cas_n in reset", dram_cas_n, 1);
    chk("R1 rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    issue(5, 5);          // R3 first access is complete
    issue(5, 7);          // R4 page hit, back to back
    issue(5, 2047);       // R4 last column
    repeat (3) @(negedge clk);
    issue(5, 0);          // R4 after idle gap
    issue(9, 3);          // R5 row change
    issue(8191, 1);       // R5 top row
    issue(8191, 2);
    req_valid = 1'b1;     // R6 request while busy is ignored
    req_addr  = {13'd0, 11'd77};
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    issue(8191, 9);       // R6 still a page hit on the open row
    issue(0, 0);
    issue(0, 1024);
    repeat (30) @(negedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog act=hung exp=finished");
      summary();
    end
  end
endmodule